// File: doc/BRIEF.md
# Triggered Circular Trace Buffer

This block records a vector of debug samples, one per clock, into a ring of storage once it has been armed. A programmable trigger condition, built from masked comparisons on a small set of trigger inputs, marks the event of interest. A pre-trigger percentage, latched at arm time, divides the ring into history kept from before the event and samples recorded after it. When the post-trigger quota has been recorded, capture freezes.

After capture is complete, the stored samples are read out one per request. Readout starts at the oldest surviving sample and proceeds in time order. The block reports how many samples are valid and where in the readout sequence the trigger sample sits. If the trigger arrives before the pre-trigger history has filled, only the samples actually recorded are reported and returned.

Top module: `trace_capture_top`

## Requirements
- R1: A one-cycle `arm` pulse starts a fresh capture. From the next cycle `st_armed` is 1, `st_triggered` and `st_done` are 0, `stored_count` is 0, and one sample is recorded on every clock edge after that.
- R2: With `cfg_or_mode`=0, the trigger fires when every bit of `trig_in` selected by a 1 in `cfg_mask` equals the same bit of `cfg_value`. An all-zero mask fires on the first recorded sample.
- R3: With `cfg_or_mode`=1, the trigger fires when at least one bit selected by `cfg_mask` equals the same bit of `cfg_value`. An all-zero mask never fires, and recording continues indefinitely.
- R4: Let p = min(`cfg_pre_pct`, 100). The pre-trigger share is pre = min(floor(DEPTH*p/100), DEPTH-1), and post = DEPTH-pre. The trigger sample counts as the first of the post samples. Exactly post samples are recorded from the trigger sample onward, and then `st_done` rises while `st_armed` falls.
- R5: Once `st_done` is set, no further samples are written until the next `arm`. `stored_count`, `trig_pos` and the stored data stay unchanged regardless of `smp_data` and `trig_in`.
- R6: `stored_count` equals the number of samples recorded since `arm`, saturating at DEPTH. If the trigger comes early, only pre-trigger samples that were actually recorded are counted.
- R7: While `st_done`=1, each `rd_req` pulse with unread samples remaining makes `rd_valid` high for exactly one cycle, on the cycle after the request, with the next sample on `rd_data`. The first sample returned is the oldest stored one, and later samples follow in recording order. Requests beyond `stored_count`, or made before done, give no `rd_valid`.
- R8: When done, `trig_pos` = `stored_count` - post. This is the zero-based readout index of the trigger sample.
- R9: After reset, `st_armed`, `st_triggered`, `st_done`, `rd_valid` and `stored_count` are all 0.
- R10: An `arm` pulse during an ongoing capture discards it and restarts capture as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Start or restart a capture (one-cycle pulse) |
| smp_data | input | W | Sample vector recorded each cycle while armed |
| trig_in | input | TW | Trigger signals |
| cfg_mask | input | TW | Selects the trigger bits that take part in the comparison |
| cfg_value | input | TW | Value the selected trigger bits are compared against |
| cfg_or_mode | input | 1 | 0: all selected bits must match; 1: any selected bit matching is enough |
| cfg_pre_pct | input | 7 | Pre-trigger percentage, latched at arm; values above 100 act as 100 |
| rd_req | input | 1 | Request the next stored sample |
| rd_data | output | W | Returned sample |
| rd_valid | output | 1 | `rd_data` is valid this cycle |
| st_armed | output | 1 | Capture in progress |
| st_triggered | output | 1 | Trigger has been seen in this capture |
| st_done | output | 1 | Capture complete, buffer frozen |
| stored_count | output | $clog2(DEPTH)+1 | Number of valid stored samples |
| trig_pos | output | $clog2(DEPTH)+1 | Readout index of the trigger sample |

## Verification
The assertions assume that `rd_req` and `arm` are single-cycle pulses. They also assume that mask, value and OR mode stay steady during a capture, and that DEPTH is a power of two so the ring pointers wrap naturally. The bench changes configuration only in the cycle it pulses `arm`. It drives every request as an isolated one-cycle pulse separated by an idle cycle. Trigger patterns are chosen so that the non-trigger pattern cannot satisfy the condition in the selected mode, which places the trigger on an exactly known sample.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_POST = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;
endpackage

// File: rtl/trace_match.sv
module trace_match #(
  parameter int TW = 4
) (
  input  logic [TW-1:0] trig,
  input  logic [TW-1:0] mask,
  input  logic [TW-1:0] value,
  input  logic          or_mode,
  output logic          hit
);
  logic [TW-1:0] eq_bits;

  always_comb begin
    eq_bits = ~(trig ^ value);
    if (or_mode) hit = |(mask & eq_bits);   // any selected bit equal
    else         hit = &(~mask | eq_bits);  // all selected bits equal
  end
endmodule

// File: rtl/trace_mem.sv
module trace_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= store_q[rd_addr];
  end
endmodule

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1,
  localparam int PW   = AW + 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          hit,
  input  logic [6:0]    pct,
  input  logic          rd_req,
  output logic          we,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          rd_valid,
  output logic          armed,
  output logic          triggered,
  output logic          done,
  output logic [CW-1:0] stored_count,
  output logic [CW-1:0] trig_pos
);
  cap_state_e    st_q, st_d;
  logic [AW-1:0] wp_q, wp_d;
  logic [CW-1:0] wc_q, wc_d;
  logic [CW-1:0] pl_q, pl_d;
  logic [CW-1:0] post_q, post_d;
  logic [CW-1:0] ri_q, ri_d;
  logic          rv_q;

  logic [6:0]    pct_c;
  logic [PW-1:0] prod, pre_raw, pre_c;
  logic [CW-1:0] post_new;
  logic [AW-1:0] oldest;

  // pre/post split from the percentage
  always_comb begin
    pct_c    = (pct > 7'd100) ? 7'd100 : pct;
    prod     = PW'(DEPTH) * PW'(pct_c);
    pre_raw  = prod / PW'(100);
    pre_c    = (pre_raw > PW'(DEPTH - 1)) ? PW'(DEPTH - 1) : pre_raw;
    post_new = CW'(DEPTH) - CW'(pre_c);
  end

  // next-state logic
  always_comb begin
    st_d   = st_q;
    wp_d   = wp_q;
    wc_d   = wc_q;
    pl_d   = pl_q;
    post_d = post_q;
    ri_d   = ri_q;
    we     = 1'b0;
    rd_en  = 1'b0;
    if (arm) begin
      st_d   = ST_PRE;
      wp_d   = '0;
      wc_d   = '0;
      ri_d   = '0;
      post_d = post_new;
      pl_d   = post_new;
    end else if (st_q == ST_PRE || st_q == ST_POST) begin
      we   = 1'b1;
      wp_d = wp_q + AW'(1);
      if (wc_q != CW'(DEPTH)) wc_d = wc_q + CW'(1);
      if (st_q == ST_PRE) begin
        if (hit) begin
          pl_d = post_q - CW'(1);
          st_d = (post_q == CW'(1)) ? ST_DONE : ST_POST;
        end
      end else begin
        pl_d = pl_q - CW'(1);
        if (pl_q == CW'(1)) st_d = ST_DONE;
      end
    end else if (st_q == ST_DONE && rd_req && ri_q < wc_q) begin
      rd_en = 1'b1;
      ri_d  = ri_q + CW'(1);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wp_q   <= '0;
      wc_q   <= '0;
      pl_q   <= '0;
      post_q <= CW'(DEPTH);
      ri_q   <= '0;
      rv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      wp_q   <= wp_d;
      wc_q   <= wc_d;
      pl_q   <= pl_d;
      post_q <= post_d;
      ri_q   <= ri_d;
      rv_q   <= rd_en;
    end
  end

  assign oldest       = wp_q - wc_q[AW-1:0];
  assign wr_addr      = wp_q;
  assign rd_addr      = oldest + ri_q[AW-1:0];
  assign rd_valid     = rv_q;
  assign armed        = (st_q == ST_PRE) || (st_q == ST_POST);
  assign triggered    = (st_q == ST_POST) || (st_q == ST_DONE);
  assign done         = (st_q == ST_DONE);
  assign stored_count = wc_q;
  assign trig_pos     = wc_q - post_q;

  // R8: trigger sample lies inside the stored window
  a_r8_trig_inside: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (trig_pos < stored_count));

  // R5: frozen once done
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && !arm) |=> ($stable(wp_q) && $stable(wc_q)));

  // R7: a returned sample always answers a request made while done
  a_r7_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(rd_req) && $past(st_q == ST_DONE)));

  // R4: trigger only while a capture runs
  a_r4_trig_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(triggered) |-> $past(armed));

  // R6: count never exceeds the ring size
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    stored_count <= CW'(DEPTH));
endmodule

// File: rtl/trace_capture_top.sv
module trace_capture_top #(
  parameter int W     = 8,
  parameter int TW    = 4,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic [W-1:0]  smp_data,
  input  logic [TW-1:0] trig_in,
  input  logic [TW-1:0] cfg_mask,
  input  logic [TW-1:0] cfg_value,
  input  logic          cfg_or_mode,
  input  logic [6:0]    cfg_pre_pct,
  input  logic          rd_req,
  output logic [W-1:0]  rd_data,
  output logic          rd_valid,
  output logic          st_armed,
  output logic          st_triggered,
  output logic          st_done,
  output logic [CW-1:0] stored_count,
  output logic [CW-1:0] trig_pos
);
  logic          hit;
  logic          we, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;

  trace_match #(.TW(TW)) u_match (
    .trig(trig_in), .mask(cfg_mask), .value(cfg_value),
    .or_mode(cfg_or_mode), .hit(hit)
  );

  trace_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm(arm), .hit(hit), .pct(cfg_pre_pct),
    .rd_req(rd_req), .we(we), .wr_addr(wr_addr), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .armed(st_armed),
    .triggered(st_triggered), .done(st_done),
    .stored_count(stored_count), .trig_pos(trig_pos)
  );

  trace_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(we), .wr_addr(wr_addr), .wr_data(smp_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_trace_capture_top.sv
`timescale 1ns/1ps
module tb_trace_capture_top;
  localparam int W = 8, TW = 4, DEPTH = 16, CW = 5;

  logic          clk = 1'b0;
  logic          rst_n, arm, cfg_or_mode, rd_req;
  logic [W-1:0]  smp_data;
  logic [TW-1:0] trig_in, cfg_mask, cfg_value;
  logic [6:0]    cfg_pre_pct;
  logic [W-1:0]  rd_data;
  logic          rd_valid, st_armed, st_triggered, st_done;
  logic [CW-1:0] stored_count, trig_pos;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [W-1:0] expq [$];
  logic [W-1:0] exp_item;

  trace_capture_top #(.W(W), .TW(TW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_data(smp_data),
    .trig_in(trig_in), .cfg_mask(cfg_mask), .cfg_value(cfg_value),
    .cfg_or_mode(cfg_or_mode), .cfg_pre_pct(cfg_pre_pct), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .st_armed(st_armed),
    .st_triggered(st_triggered), .st_done(st_done),
    .stored_count(stored_count), .trig_pos(trig_pos)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // monitor: scoreboard for readout (R7)
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R7 unexpected rd_valid actual=%0h expected=none", rd_data);
      end else begin
        exp_item = expq.pop_front();
        chk("R7 readout order", int'(rd_data), int'(exp_item));
      end
    end
  end

  task automatic run(input string tag, input int base, input int t, input int pct,
                     input logic orm, input logic [TW-1:0] mask, input logic [TW-1:0] val,
                     input logic [TW-1:0] hitp, input logic [TW-1:0] missp);
    int p, pre, post, total, stored, oldest, k;
    p      = (pct > 100) ? 100 : pct;
    pre    = DEPTH * p / 100;
    if (pre > DEPTH - 1) pre = DEPTH - 1;
    post   = DEPTH - pre;
    total  = t + post;
    stored = (total < DEPTH) ? total : DEPTH;
    oldest = total - stored;
    $display("-- %s", tag);
    @(negedge clk);
    cfg_or_mode = orm; cfg_mask = mask; cfg_value = val; cfg_pre_pct = 7'(pct);
    arm = 1'b1; trig_in = missp;
    @(negedge clk);
    arm = 1'b0;
    chk("R1 R10 armed after arm", int'(st_armed), 1);
    chk("R1 R10 triggered after arm", int'(st_triggered), 0);
    chk("R1 R10 count after arm", int'(stored_count), 0);
    k = 0;
    while (!st_done && k < 200) begin
      smp_data = W'(base + k);
      trig_in  = (k == t) ? hitp : missp;
      @(negedge clk);
      k++;
    end
    chk("R4 samples recorded", k, total);
    chk("R4 done flags", int'({st_armed, st_triggered, st_done}), 3);
    chk("R6 stored_count", int'(stored_count), stored);
    chk("R8 trig_pos", int'(trig_pos), stored - post);
    repeat (5) begin
      smp_data = 8'hEE; trig_in = hitp;
      @(negedge clk);
    end
    chk("R5 frozen count", int'(stored_count), stored);
    chk("R5 frozen trig_pos", int'(trig_pos), stored - post);
    for (int j = 0; j < stored; j++) expq.push_back(W'(base + oldest + j));
    repeat (stored + 1) begin
      rd_req = 1'b1; @(negedge clk);
      rd_req = 1'b0; @(negedge clk);
    end
    chk("R7 all samples returned", expq.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; arm = 1'b0; rd_req = 1'b0; smp_data = '0; trig_in = '0;
    cfg_mask = '0; cfg_value = '0; cfg_or_mode = 1'b0; cfg_pre_pct = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset flags", int'({st_armed, st_triggered, st_done}), 0);
    chk("R9 reset count", int'(stored_count), 0);
    chk("R9 reset rd_valid", int'(rd_valid), 0);

    // R2 AND mode, 25% pre, late trigger: full ring
    run("R2 and mode pct25", 8'h10, 10, 25, 1'b0, 4'b1010, 4'b1000, 4'b1101, 4'b0111);
    // R6 early trigger: fewer pre samples than asked
    run("R6 early trigger pct50", 8'h40, 3, 50, 1'b0, 4'b1111, 4'b0101, 4'b0101, 4'b1010);
    // R3 OR mode, 0% pre
    run("R3 or mode pct0", 8'h80, 5, 0, 1'b1, 4'b0011, 4'b0001, 4'b0011, 4'b0010);
    // R4 clamp at 100 and above
    run("R4 pct100", 8'hA0, 20, 100, 1'b0, 4'b0001, 4'b0001, 4'b0001, 4'b0000);
    run("R4 pct120", 8'hC0, 20, 120, 1'b0, 4'b0001, 4'b0001, 4'b0001, 4'b0000);
    // R2 AND mode with empty mask fires on first sample
    run("R2 empty mask", 8'h20, 0, 50, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000);

    // R3 OR mode with empty mask never fires; read attempt while capturing
    @(negedge clk);
    cfg_or_mode = 1'b1; cfg_mask = 4'b0000; cfg_value = 4'b0000; cfg_pre_pct = 7'd50;
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    for (int k = 0; k < 40; k++) begin
      smp_data = W'(k); trig_in = TW'(k);
      rd_req = (k == 7);
      @(negedge clk);
    end
    rd_req = 1'b0;
    @(negedge clk);
    chk("R3 never triggered", int'(st_triggered), 0);
    chk("R3 still armed", int'(st_armed), 1);
    chk("R6 count saturates", int'(stored_count), DEPTH);
    // R10 restart mid-capture
    run("R10 rearm during capture", 8'h60, 12, 75, 1'b0, 4'b0100, 4'b0100, 4'b0100, 4'b0000);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule